// File: doc/BRIEF.md
# Block-Cipher Subkey Expander and Inverter

This block turns a 128-bit cipher key into the 52 sixteen-bit subkeys of a 64-bit block cipher built from eight full rounds and one output half-round. A full round consumes six subkeys and the half-round consumes four. The encryption set is read out of a key register that is rotated left by 25 bits after every eight words. When the load asks for decryption, the block then derives the decryption set from the encryption set. It reverses the group order, replaces each multiplicative subkey with its inverse modulo 65537, and replaces each additive subkey with its negation modulo 65536. In the inner rounds the two additive subkeys also trade places.

Software or a cipher datapath starts a run by pulsing `load` with the key and the `dec_mode` bit. It waits for `done`, then fetches any subkey by index through a combinational read port. Multiplicative inverses come from a sequential exponentiation unit that raises the value to the power 65535 with modular multiplies. Each inverse therefore takes a fixed number of cycles, and the block needs no divider.

Top module: `idea_ks_top`

## Requirements
- R1: After reset, `busy` and `done` are both 0.
- R2: A `load` pulse seen while `busy` is 0 starts a run: in the next cycle `busy` is 1 and `done` is 0.
- R3: In encryption mode, subkey i (0 to 51) is 16-bit word (i mod 8) of the key rotated left by 25*(i div 8) bits, where word 0 is bits 127:112 and word 7 is bits 15:0.
- R4: An encryption run keeps `busy` high for exactly 52 cycles. Then `done` goes to 1 and stays at 1 until the next accepted load, and `busy` and `done` are never both 1.
- R5: In decryption mode, output group g (0 to 8) is built from encryption group 8-g. For g below 8, outputs 6g+4 and 6g+5 are encryption subkeys 6(7-g)+4 and 6(7-g)+5, copied unchanged.
- R6: Decryption outputs 6g and 6g+3 are the multiplicative inverses modulo 65537 of encryption subkeys 6(8-g) and 6(8-g)+3. The code 0 stands for 65536, so 0 maps to 0 and 1 maps to 1.
- R7: Decryption outputs 6g+1 and 6g+2 are negations modulo 65536 of encryption subkeys 6(8-g)+1 and 6(8-g)+2, in that order, for g = 0 and g = 8.
- R8: For the inner groups g = 1 to 7, the two negated subkeys trade places: output 6g+1 comes from encryption subkey 6(8-g)+2, and output 6g+2 comes from 6(8-g)+1.
- R9: A `load` pulse that arrives while `busy` is 1 is ignored. The run in progress completes with its own key and mode, and its 52-cycle timing is unchanged.
- R10: While `done` is 1, `rd_key` shows the subkey at `rd_idx`, drawn from the set chosen by the mode of the last accepted load, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a run with `key_in` and `dec_mode` |
| dec_mode | input | 1 | 1 selects the decryption set, 0 the encryption set |
| key_in | input | 128 | Cipher key |
| busy | output | 1 | Run in progress |
| done | output | 1 | Subkey set ready to read |
| rd_idx | input | 6 | Subkey index, 0 to 51 |
| rd_key | output | 16 | Subkey at `rd_idx` |

## Verification
Two things can land in the same cycle here: a new load request and a run that is still working. The bench provokes this by pulsing `load` with a different key and the opposite mode partway through an encryption run. It then judges the result by two checks: the busy interval must still be exactly 52 cycles, and every one of the 52 subkeys read afterwards must match the first key's encryption set. The swept keys include all-zero, all-ones and unit words, so the 0 and 1 inverse corners and the inner-round swap land on every decryption position.

// File: rtl/idea_ks_pkg.sv
package idea_ks_pkg;
    localparam int KEY_W   = 128;
    localparam int WORD_W  = 16;
    localparam int NUM_SUB = 52;
    localparam int GRP     = 6;
    localparam int ROT_AMT = 25;
    localparam int IDX_W   = $clog2(NUM_SUB);
    localparam int WPK     = KEY_W / WORD_W;
    localparam int LAST_G  = (NUM_SUB - 4) / GRP;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {OP_COPY, OP_NEG, OP_MINV} op_e;

    typedef struct packed {
        logic [IDX_W-1:0] src;
        op_e              op;
    } dmap_t;

    typedef enum logic [1:0] {ST_IDLE, ST_EXPAND, ST_INVERT, ST_DONE} st_e;

    // multiply modulo 2^16+1, code 0 stands for 2^16
    function automatic word_t mul_mod(word_t a, word_t b);
        logic [2*WORD_W-1:0] p;
        word_t lo, hi;
        if (a == '0) return word_t'(1) - b;
        if (b == '0) return word_t'(1) - a;
        p  = (2*WORD_W)'(a) * (2*WORD_W)'(b);
        lo = p[WORD_W-1:0];
        hi = p[2*WORD_W-1:WORD_W];
        return lo - hi + ((lo < hi) ? word_t'(1) : word_t'(0));
    endfunction

    // decryption output j -> encryption source and operation
    function automatic dmap_t dec_map(logic [IDX_W-1:0] j);
        int g, p, b;
        logic inner;
        dmap_t m;
        g = int'(j) / GRP;
        p = int'(j) % GRP;
        b = GRP * (LAST_G - g);
        inner = (g >= 1) && (g < LAST_G);
        m.src = '0;
        m.op  = OP_COPY;
        case (p)
            0: begin m.src = IDX_W'(b);     m.op = OP_MINV; end
            1: begin m.src = inner ? IDX_W'(b + 2) : IDX_W'(b + 1); m.op = OP_NEG; end
            2: begin m.src = inner ? IDX_W'(b + 1) : IDX_W'(b + 2); m.op = OP_NEG; end
            3: begin m.src = IDX_W'(b + 3); m.op = OP_MINV; end
            4: begin m.src = IDX_W'(b - 2); m.op = OP_COPY; end
            default: begin m.src = IDX_W'(b - 1); m.op = OP_COPY; end
        endcase
        return m;
    endfunction
endpackage

// File: rtl/idea_ks_rotor.sv
module idea_ks_rotor
    import idea_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [KEY_W-1:0] key,
    input  logic             step,
    output word_t            word
);
    localparam int SUB_W = $clog2(WPK);

    logic [KEY_W-1:0] reg_q;
    logic [SUB_W-1:0] sub_q;

    assign word = reg_q[KEY_W-1 - WORD_W*int'(sub_q) -: WORD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            sub_q <= '0;
        end else if (load) begin
            reg_q <= key;
            sub_q <= '0;
        end else if (step) begin
            if (sub_q == SUB_W'(WPK - 1)) begin
                reg_q <= {reg_q[KEY_W-1-ROT_AMT:0], reg_q[KEY_W-1 -: ROT_AMT]};
                sub_q <= '0;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/idea_ks_inv_unit.sv
module idea_ks_inv_unit
    import idea_ks_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t x,
    output logic  vld,
    output word_t y
);
    localparam int ITERS = WORD_W;
    localparam int IT_W  = $clog2(ITERS);

    word_t acc_q, base_q;
    logic [IT_W-1:0] it_q;
    logic run_q, vld_q;

    // x^(2^16-1) = x^-1 modulo the prime 2^16+1
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= word_t'(1);
            base_q <= '0;
            it_q   <= '0;
            run_q  <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (start) begin
                acc_q  <= word_t'(1);
                base_q <= x;
                it_q   <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                acc_q  <= mul_mod(acc_q, base_q);
                base_q <= mul_mod(base_q, base_q);
                it_q   <= it_q + 1'b1;
                if (it_q == IT_W'(ITERS - 1)) begin
                    run_q <= 1'b0;
                    vld_q <= 1'b1;
                end
            end
        end
    end

    assign vld = vld_q;
    assign y   = acc_q;
endmodule

// File: rtl/idea_ks_top.sv
module idea_ks_top
    import idea_ks_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               dec_mode,
    input  logic [KEY_W-1:0]   key_in,
    output logic               busy,
    output logic               done,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_key
);
    st_e              st_q;
    logic             mode_q;
    logic [IDX_W-1:0] cnt_q;
    logic             wait_q;

    word_t enc_mem [NUM_SUB];
    word_t dec_mem [NUM_SUB];

    word_t rot_word, src_w, inv_y;
    logic  accept, inv_start, inv_vld, last_idx, step_ok;
    dmap_t map;

    assign busy     = (st_q == ST_EXPAND) || (st_q == ST_INVERT);
    assign done     = (st_q == ST_DONE);
    assign accept   = load && !busy;
    assign last_idx = (cnt_q == IDX_W'(NUM_SUB - 1));

    idea_ks_rotor rot_i (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .key  (key_in),
        .step (st_q == ST_EXPAND),
        .word (rot_word)
    );

    assign map       = dec_map(cnt_q);
    assign src_w     = enc_mem[map.src];
    assign inv_start = (st_q == ST_INVERT) && (map.op == OP_MINV) && !wait_q;
    assign step_ok   = (map.op != OP_MINV) || (wait_q && inv_vld);

    idea_ks_inv_unit inv_i (
        .clk   (clk),
        .rst   (rst),
        .start (inv_start),
        .x     (src_w),
        .vld   (inv_vld),
        .y     (inv_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= 1'b0;
            cnt_q  <= '0;
            wait_q <= 1'b0;
        end else begin
            case (st_q)
                ST_EXPAND: begin
                    if (last_idx) begin
                        cnt_q <= '0;
                        st_q  <= mode_q ? ST_INVERT : ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_INVERT: begin
                    if (inv_start) wait_q <= 1'b1;
                    if (step_ok) begin
                        wait_q <= 1'b0;
                        if (last_idx) begin
                            cnt_q <= '0;
                            st_q  <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (load) begin
                        st_q   <= ST_EXPAND;
                        mode_q <= dec_mode;
                        cnt_q  <= '0;
                        wait_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (st_q == ST_EXPAND) enc_mem[cnt_q] <= rot_word;
        if (st_q == ST_INVERT) begin
            case (map.op)
                OP_COPY: dec_mem[cnt_q] <= src_w;
                OP_NEG:  dec_mem[cnt_q] <= word_t'(0) - src_w;
                default: if (wait_q && inv_vld) dec_mem[cnt_q] <= inv_y;
            endcase
        end
    end

    always_comb begin
        rd_key = '0;
        if (int'(rd_idx) < NUM_SUB)
            rd_key = mode_q ? dec_mem[rd_idx] : enc_mem[rd_idx];
    end
endmodule

// File: rtl/idea_ks_chk.sv
module idea_ks_chk
    import idea_ks_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic              busy,
    input logic              done,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [WORD_W-1:0] rd_key
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done)); // R1

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> (busy && !done)); // R2

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> done); // R4

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy)); // R4

    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (busy && load) |=> (busy || done)); // R9

    AST_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done) && !$past(load) && $stable(rd_idx)) |-> $stable(rd_key)); // R10
endmodule

bind idea_ks_top idea_ks_chk chk_i (.*);

// File: tb/idea_ks_tb.sv
module idea_ks_top_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic         dec_mode = 1'b0;
    logic [127:0] key_in = '0;
    logic         busy, done;
    logic [5:0]   rd_idx = '0;
    logic [15:0]  rd_key;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    idea_ks_top dut_i (
        .clk(clk), .rst(rst), .load(load), .dec_mode(dec_mode), .key_in(key_in),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_key(rd_key)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] m_enc(logic [127:0] k, int i);
        int n;
        logic [127:0] r;
        n = (25 * (i / 8)) % 128;
        r = (n == 0) ? k : ((k << n) | (k >> (128 - n)));
        return r[127 - 16*(i % 8) -: 16];
    endfunction

    function automatic logic [15:0] m_minv(logic [15:0] x);
        longint t, nt, r, nr, q, tmp;
        if (x == 16'd0) return 16'd0;
        t = 0; nt = 1; r = 65537; nr = longint'(x);
        while (nr != 0) begin
            q = r / nr;
            tmp = t - q*nt; t = nt; nt = tmp;
            tmp = r - q*nr; r = nr; nr = tmp;
        end
        if (t < 0) t += 65537;
        return 16'(t);
    endfunction

    function automatic logic [15:0] m_dec(logic [127:0] k, int j);
        int g, p, s;
        logic inner;
        g = j / 6; p = j % 6; s = 8 - g;
        inner = (g >= 1) && (g <= 7);
        case (p)
            0: return m_minv(m_enc(k, 6*s));
            1: return 16'd0 - m_enc(k, inner ? 6*s+2 : 6*s+1);
            2: return 16'd0 - m_enc(k, inner ? 6*s+1 : 6*s+2);
            3: return m_minv(m_enc(k, 6*s+3));
            4: return m_enc(k, 6*(s-1)+4);
            default: return m_enc(k, 6*(s-1)+5);
        endcase
    endfunction

    function automatic string dec_tag(int j);
        int g, p;
        g = j / 6; p = j % 6;
        if (p == 0 || p == 3) return "R6";
        if (p == 4 || p == 5) return "R5";
        if (g >= 1 && g <= 7) return "R8";
        return "R7";
    endfunction

    // drives a load, counts busy cycles, optionally interferes mid-run
    task automatic run(logic [127:0] k, logic m, bit poke, output int nbusy);
        @(negedge clk);
        key_in = k; dec_mode = m; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R2 busy", 32'(busy), 32'd1);
        check("R2 done", 32'(done), 32'd0);
        nbusy = 0;
        while (busy && nbusy < 2000) begin
            nbusy++;
            if (poke && nbusy == 10) begin
                key_in = ~k; dec_mode = ~m; load = 1'b1;
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
        end
        load = 1'b0;
        key_in = k; dec_mode = m;
        check("R4 done", 32'(done), 32'd1);
    endtask

    task automatic read_all(logic [127:0] k, logic m);
        for (int i = 0; i < 52; i++) begin
            rd_idx = 6'(i);
            #1;
            if (m) begin
                check(dec_tag(i), 32'(rd_key), 32'(m_dec(k, i)));
                if (i % 6 == 0 || i % 6 == 3) begin
                    longint a, b;
                    a = (rd_key == 0) ? 65536 : longint'(rd_key);
                    b = (m_enc(k, 6*(8 - i/6) + i%6) == 0) ? 65536
                        : longint'(m_enc(k, 6*(8 - i/6) + i%6));
                    check("R6 product", 32'((a*b) % 65537), 32'd1);
                end
            end else begin
                check("R3", 32'(rd_key), 32'(m_enc(k, i)));
            end
        end
    endtask

    logic [127:0] keys [6];

    initial begin
        int nb;
        keys[0] = '0;
        keys[1] = '1;
        keys[2] = {8{16'h0001}};
        keys[3] = 128'h0001_0002_0003_0004_0005_0006_0007_0008;
        keys[4] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        keys[5] = 128'h8000_0000_FFFF_0001_5A5A_A5A5_0000_0001;

        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);

        for (int t = 0; t < 6; t++) begin
            run(keys[t], 1'b0, 1'b0, nb);
            check("R4 busy cycles", 32'(nb), 32'd52);
            read_all(keys[t], 1'b0);
            repeat (5) @(negedge clk);
            check("R4 done held", 32'(done), 32'd1);
            run(keys[t], 1'b1, 1'b0, nb);
            read_all(keys[t], 1'b1);
        end

        // R9: load during a run is ignored
        run(keys[4], 1'b0, 1'b1, nb);
        check("R9 busy cycles", 32'(nb), 32'd52);
        read_all(keys[4], 1'b0);

        // R10: held index, held output
        rd_idx = 6'd7;
        #1;
        begin
            logic [15:0] v;
            v = rd_key;
            repeat (3) @(negedge clk);
            check("R10 read held", 32'(rd_key), 32'(v));
            check("R10 value", 32'(rd_key), 32'(m_enc(keys[4], 7)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule